// File: doc/BRIEF.md
# Programmable Sum-of-Products Cell with Fixed Term Allocation

This block evaluates three Boolean functions of four inputs as sums of products. Every input is offered to every product term both as its true value and as its complement. Which of those eight literals a term uses is the only thing that can be configured. The way terms feed the outputs is wired in. Output 0 ORs terms 0 to 2, output 1 ORs terms 3 to 5, and output 2 ORs terms 6 and 7. Terms are never shared between outputs, so output 2 can only realise functions that need two products or fewer.

The 64 connection bits are loaded serially. While the shift enable is high, one bit enters a 64-bit chain on each clock. A single commit pulse then copies the whole chain into the active connection store in one step. The outputs are a purely combinational function of the inputs and the committed store. The end of the chain is visible on a readback pin, so configuration data can be cascaded or verified.

Top module: `pal_cell`

## Requirements
- R1: Synchronous active-high reset sets every connection bit of both the chain and the committed store to 1 (intact). Right after reset all outputs are 0 for any input and the readback pin is 1.
- R2: When `cfg_shift` is high, each rising clock edge shifts `cfg_bit` into the least significant end of the 64-bit chain. `cfg_tail` always shows the most significant chain bit, which is the bit shifted in 64 shifts earlier. When `cfg_shift` is low, the chain holds its value.
- R3: The committed store changes only on a clock edge where `cfg_commit` is high. Shifting without a commit has no effect on the outputs.
- R4: On a commit edge the store takes the chain content as it stood before that edge. This holds even when a shift happens on the same edge.
- R5: The data is sent term 0 first, and within each term the most significant bit first. So after 64 shifts, term t occupies chain bits [63-8t : 56-8t]. Inside a term's byte, bit 2i is the true literal of `din[i]` and bit 2i+1 is its complement. A literal enters the term's product only when its bit is 1.
- R6: A term whose eight bits are all 1 evaluates to 0, because it contains both a literal and its complement. An output whose terms are all like this is 0.
- R7: The OR plane is fixed. `dout[0]` is the OR of terms 0, 1 and 2. `dout[1]` is the OR of terms 3, 4 and 5. `dout[2]` is the OR of terms 6 and 7.
- R8: A term whose eight bits are all 0 has no literals and evaluates to 1.
- R9: The outputs follow `din` combinationally, with no clock between them.
- R10: Output 2 has only two product terms. A function that needs three products, such as the three-input majority, cannot be realised there: a two-term attempt differs from it on at least one input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one configuration bit into the chain |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copy the chain into the active connection store |
| din | input | 4 | Logic inputs |
| dout | output | 3 | Sum-of-products outputs |
| cfg_tail | output | 1 | Most significant chain bit (readback) |

## Verification
A shift and a commit can happen on the same clock edge. The bench loads a full configuration and then raises `cfg_commit` together with one extra `cfg_shift`. It then checks all sixteen input patterns against truth tables written out from minterm lists. If the store had captured the chain after the extra shift, every term would be misaligned by one bit and the outputs would differ. A later load with no commit shows that the outputs keep their old values. The readback pin is checked against the history of shifted bits, including the extra one.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int N_IN   = 4;
    localparam int N_OUT  = 3;
    localparam int N_LIT  = 2 * N_IN;
    localparam int N_TERM = 8;
    localparam int CFG_W  = N_TERM * N_LIT;

    typedef logic [N_LIT-1:0]              lit_vec_t;
    typedef lit_vec_t [N_TERM-1:0]         plane_t;
    typedef logic [N_TERM-1:0]             term_vec_t;

    // Fixed allocation of product terms to outputs.
    function automatic int grp_base(input int o);
        return (o == 0) ? 0 : ((o == 1) ? 3 : 6);
    endfunction

    function automatic int grp_size(input int o);
        return (o == 2) ? 2 : 3;
    endfunction

    // Literal lines for one input vector: bit 2i true, bit 2i+1 complement.
    function automatic lit_vec_t literals(input logic [N_IN-1:0] x);
        lit_vec_t l;
        for (int i = 0; i < N_IN; i++) begin
            l[2*i]   = x[i];
            l[2*i+1] = ~x[i];
        end
        return l;
    endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain
    import pal_pkg::*;
#(
    parameter int TERMS = N_TERM,
    parameter int LITS  = N_LIT,
    localparam int W    = TERMS * LITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic                  shift_bit,
    input  logic                  commit,
    output logic [TERMS-1:0][LITS-1:0] mask,
    output logic                  tail
);

    logic [W-1:0] chain_q;
    logic [W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else if (shift_en) begin
            chain_q <= {chain_q[W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '1;
        end else if (commit) begin
            store_q <= chain_q;
        end
    end

    assign tail = chain_q[W-1];

    // Term 0 was shifted first, so it sits at the top of the store.
    for (genvar t = 0; t < TERMS; t++) begin : g_unpack
        assign mask[t] = store_q[W-1-t*LITS -: LITS];
    end

    // R1: reset leaves every connection intact
    a_r1_reset_intact: assert property (@(posedge clk)
        rst |=> (&chain_q && &store_q));

    // R2: one bit per enabled edge moves toward the tail
    a_r2_chain_advance: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> tail == $past(chain_q[W-2]));

    a_r2_chain_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain_q));

    // R3: no commit, no change to the active store
    a_r3_store_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(store_q));

    // R4: commit captures the pre-edge chain even with a shift alongside
    a_r4_commit_pre_shift: assert property (@(posedge clk) disable iff (rst)
        commit |=> store_q == $past(chain_q));

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
    import pal_pkg::*;
#(
    parameter int INPUTS = N_IN,
    parameter int TERMS  = N_TERM,
    localparam int LITS  = 2 * INPUTS
) (
    input  logic [INPUTS-1:0]          din,
    input  logic [TERMS-1:0][LITS-1:0] mask,
    output logic [TERMS-1:0]           term
);

    logic [LITS-1:0] lines;

    always_comb begin
        for (int i = 0; i < INPUTS; i++) begin
            lines[2*i]   = din[i];
            lines[2*i+1] = ~din[i];
        end
    end

    // A blown connection (0) forces that literal to 1 in the product.
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign term[t] = &(~mask[t] | lines);
    end

endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane
    import pal_pkg::*;
#(
    parameter int TERMS   = N_TERM,
    parameter int OUTPUTS = N_OUT
) (
    input  logic [TERMS-1:0]   term,
    output logic [OUTPUTS-1:0] dout
);

    for (genvar o = 0; o < OUTPUTS; o++) begin : g_out
        localparam int BASE = grp_base(o);
        localparam int CNT  = grp_size(o);
        assign dout[o] = |term[BASE +: CNT];
    end

endmodule

// File: rtl/pal_cell.sv
module pal_cell
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_bit,
    input  logic             cfg_commit,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout,
    output logic             cfg_tail
);

    plane_t    mask;
    term_vec_t term;

    pal_cfg_chain #(.TERMS(N_TERM), .LITS(N_LIT)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_shift),
        .shift_bit (cfg_bit),
        .commit    (cfg_commit),
        .mask      (mask),
        .tail      (cfg_tail)
    );

    pal_and_plane #(.INPUTS(N_IN), .TERMS(N_TERM)) u_and (
        .din  (din),
        .mask (mask),
        .term (term)
    );

    pal_or_plane #(.TERMS(N_TERM), .OUTPUTS(N_OUT)) u_or (
        .term (term),
        .dout (dout)
    );

    // R6: a fully intact plane drives every output low
    a_r6_intact_zero: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> dout == '0);

    // R1: outputs low on the cycle after reset
    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> dout == '0);

endmodule

// File: tb/pal_cell_test.sv
`timescale 1ns/1ps
module pal_cell_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_shift = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_commit = 1'b0;
    logic [3:0] din = 4'h0;
    logic [2:0] dout;
    logic       cfg_tail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pal_cell uut (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
        .cfg_commit(cfg_commit), .din(din), .dout(dout), .cfg_tail(cfg_tail)
    );

    typedef struct {
        logic [3:0] x;
        logic [2:0] exp;
        logic [2:0] sel;
        string      tag;
    } item_t;

    item_t sb[$];
    bit    hist[$];
    event  mon_ev;

    // Monitor: pops one expected item per trigger and compares selected outputs.
    initial begin
        forever begin
            @(mon_ev);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if ((dout & it.sel) !== (it.exp & it.sel)) begin
                    errors++;
                    $display("FAIL %s din=%h actual=%b expected=%b (mask %b)",
                             it.tag, it.x, dout, it.exp, it.sel);
                end
            end
        end
    end

    task automatic drive(input logic [3:0] x, input logic [2:0] exp,
                         input logic [2:0] sel, input string tag);
        item_t it;
        din = x;
        it.x = x; it.exp = exp; it.sel = sel; it.tag = tag;
        sb.push_back(it);
        #1;
        -> mon_ev;
        #1;
    endtask

    // Byte for one term: t = true literals used, c = complemented literals used.
    function automatic logic [7:0] pm(input logic [3:0] t, input logic [3:0] c);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            b[2*i]   = t[i];
            b[2*i+1] = c[i];
        end
        return b;
    endfunction

    task automatic load(input logic [7:0] cfg [8], input bit do_commit,
                        input bit extra_shift);
        for (int t = 0; t < 8; t++) begin
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                checks++;
                if (cfg_tail !== hist[hist.size()-64]) begin
                    errors++;
                    $display("FAIL R2 readback actual=%b expected=%b",
                             cfg_tail, hist[hist.size()-64]);
                end
                cfg_shift = 1'b1;
                cfg_bit = cfg[t][b];
                hist.push_back(cfg[t][b]);
            end
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        if (do_commit) begin
            cfg_commit = 1'b1;
            if (extra_shift) begin
                cfg_shift = 1'b1;
                cfg_bit = 1'b0;
                hist.push_back(1'b0);
            end
            @(negedge clk);
        end
        cfg_commit = 1'b0;
        cfg_shift = 1'b0;
    endtask

    task automatic commit_only();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    // Truth tables from minterm lists over (x,y,z) = din[2:0].
    localparam logic [7:0] F0 = 8'hA6; // m(1,2,5,7)
    localparam logic [7:0] F1 = 8'hE8; // m(3,5,6,7) majority
    localparam logic [7:0] F2 = 8'hAB; // m(0,1,3,5,7) = z + x'y'
    localparam logic [7:0] FB = 8'hC8; // m(3,6,7) = xy + yz

    logic [7:0] cfg_a [8];
    logic [7:0] cfg_b [8];
    logic [7:0] cfg_c [8];

    initial begin
        // z=din[0], y=din[1], x=din[2], din[3] unused
        cfg_a[0] = pm(4'b0010, 4'b0101); // x'yz'
        cfg_a[1] = pm(4'b0101, 4'b0000); // xz
        cfg_a[2] = pm(4'b0001, 4'b0010); // y'z
        cfg_a[3] = pm(4'b0110, 4'b0000); // xy
        cfg_a[4] = pm(4'b0011, 4'b0000); // yz
        cfg_a[5] = pm(4'b0101, 4'b0000); // xz
        cfg_a[6] = pm(4'b0001, 4'b0000); // z
        cfg_a[7] = pm(4'b0000, 4'b0110); // x'y'
        for (int t = 0; t < 8; t++) begin
            cfg_b[t] = 8'hFF;
            cfg_c[t] = 8'hFF;
        end
        cfg_b[6] = pm(4'b0110, 4'b0000); // xy
        cfg_b[7] = pm(4'b0011, 4'b0000); // yz
        cfg_c[0] = 8'h00;                // no literals
        for (int k = 0; k < 64; k++) hist.push_back(1'b1);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        checks++;
        if (cfg_tail !== 1'b1) begin
            errors++;
            $display("FAIL R1 cfg_tail actual=%b expected=1", cfg_tail);
        end
        for (int x = 0; x < 16; x += 5)
            drive(4'(x), 3'b000, 3'b111, "R1/R6 reset outputs");

        // R4 + R5: load with an extra shift in the commit cycle
        load(cfg_a, 1'b1, 1'b1);
        for (int x = 0; x < 16; x++)
            drive(4'(x), {F2[x[2:0]], F1[x[2:0]], F0[x[2:0]]}, 3'b111,
                  "R4/R5/R7/R9 config A");

        // R3: shift a new config without committing
        load(cfg_c, 1'b0, 1'b0);
        for (int x = 0; x < 16; x += 3)
            drive(4'(x), {F2[x[2:0]], F1[x[2:0]], F0[x[2:0]]}, 3'b111,
                  "R3 no commit keeps A");

        // R8: commit-only pulse activates config C
        commit_only();
        for (int x = 0; x < 16; x += 3)
            drive(4'(x), 3'b001, 3'b111, "R8 empty term is 1, R6 others 0");

        // R10: two-term attempt at majority on output 2
        load(cfg_b, 1'b1, 1'b0);
        for (int x = 0; x < 16; x++)
            drive(4'(x), {FB[x[2:0]], 2'b00}, 3'b111, "R10/R6 config B");
        drive(4'h5, 3'b000, 3'b100, "R10 majority(1,0,1) not reachable");
        // full majority table on output 2 would need a third term
        checks++;
        begin
            int diff = 0;
            for (int x = 0; x < 8; x++) begin
                din = 4'(x);
                #1;
                if (dout[2] !== F1[x]) diff++;
            end
            if (diff == 0) begin
                errors++;
                $display("FAIL R10 output 2 matched majority: actual=%0d diffs expected>0", diff);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule